// File: doc/BRIEF.md
# ADC Threshold Comparator with Alert Pin

This block watches a stream of signed conversion results from an analog-to-digital converter. It compares each result with a programmable low threshold and a programmable high threshold. When the result has been out of range for enough successive samples, it drives an alert pin. A small register port gives access to four 16-bit registers: the latest conversion, a configuration word, the low threshold and the high threshold.

Each result is stored left-aligned in 16 bits, and the thresholds are compared with it in that same form using signed arithmetic. The configuration word sets the following behaviour:

- how many consecutive out-of-range results are needed before the alert asserts: 1, 2 or 4, or the comparator is switched off;
- whether an asserted alert is latched;
- the pin polarity;
- the mode, either traditional (hysteresis) or window.

The result input is a valid/ready stream. `res_ready` is held high at all times, so the block never applies back-pressure. A result is taken on every clock edge at which `res_valid` is high.

Register reads are combinational: `reg_rdata` always shows the register selected by `reg_addr`. A read strobe on the conversion register releases a latched alert.

Top module: `adc_alert_cmp`

## Requirements
- R1: The register addresses are 0 = conversion (read-only), 1 = configuration, 2 = low threshold and 3 = high threshold. Every register is 16 bits wide. A write to addresses 1 to 3 is visible on `reg_rdata` after the next clock edge. A write to address 0 leaves the conversion register unchanged.
- R2: After reset the registers read as follows: configuration 0x0003, low threshold 0x8000, high threshold 0x7FFF, conversion 0x0000. `alert_o` is 1, the inactive level for the active-low polarity.
- R3: Configuration bits [1:0] form the queue field. Values 0, 1 and 2 make the alert assert on the edge that accepts the 1st, 2nd or 4th consecutive out-of-range result.
- R4: Any accepted in-range result clears the run of consecutive faults. The fault count saturates at the selected number.
- R5: In traditional mode (configuration bit 4 = 0), a result greater than the high threshold is a fault. A non-latched alert deasserts only on a result strictly below the low threshold. Results between the two thresholds leave it asserted.
- R6: In window mode (bit 4 = 1), a result greater than the high threshold or less than the low threshold is a fault. Any in-range result deasserts a non-latched alert.
- R7: With configuration bit 2 set, an asserted alert stays asserted until the conversion register is read, that is, `reg_rd_en` is high with `reg_addr` = 0 at a clock edge. If a new alert condition arrives on the same edge as the read, the alert is set.
- R8: Configuration bit 3 selects the polarity. With bit 3 = 1, `alert_o` is 1 while the alert is active. With bit 3 = 0, `alert_o` is 0 while the alert is active.
- R9: Queue value 3 disables the comparator. A write of queue value 3 forces the alert inactive from the edge of the write, even when the alert is latched, and clears the fault count. While the value is 3, no result asserts the alert.
- R10: An accepted 12-bit result d reads back from the conversion register as {d, 4'b0}. Comparisons treat the result and both thresholds as signed 16-bit numbers.
- R11: `res_ready` is 1 in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (a read of address 0 releases a latched alert) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Contents of the addressed register |
| res_valid | input | 1 | Result valid |
| res_ready | output | 1 | Result ready, always high |
| res_data | input | 12 | Signed conversion result |
| alert_o | output | 1 | Alert pin |

## Verification
The bench uses the default parameters: a 12-bit result in a 16-bit register. This leaves four zero bits below the result and makes the sign bit of the result the sign bit of the register. The signed-versus-unsigned corner of R10 is therefore reachable with one negative sample. The queue counter is three bits wide, so the saturation point of 4 and a queue change in the middle of a run can both be driven directly. A random phase mixes configuration writes, including switching off the comparator and changing polarity, with results near the thresholds. This phase runs the latch, hysteresis and window paths against each other.

// File: rtl/adc_alert_pkg.sv
package adc_alert_pkg;
  localparam int CNT_W = 3;
  localparam logic [1:0] QUEUE_OFF = 2'd3;

  typedef struct packed {
    logic       win;
    logic       pol_hi;
    logic       latch;
    logic [1:0] queue;
  } ctl_t;

  function automatic logic [CNT_W-1:0] need_count(input logic [1:0] q);
    case (q)
      2'd0:    need_count = 3'd1;
      2'd1:    need_count = 3'd2;
      2'd2:    need_count = 3'd4;
      default: need_count = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/adc_alert_regs.sv
module adc_alert_regs #(
  parameter int REG_W  = 16,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              res_fire,
  input  logic [DATA_W-1:0] res_data,
  output logic [REG_W-1:0]  rdata,
  output logic [4:0]        ctl_bits,
  output logic [REG_W-1:0]  lo_q,
  output logic [REG_W-1:0]  hi_q,
  output logic [REG_W-1:0]  conv_q
);
  localparam int SHIFT = REG_W - DATA_W;
  localparam logic [REG_W-1:0] CFG_RST = REG_W'(3);
  localparam logic [REG_W-1:0] LO_RST  = {1'b1, {(REG_W-1){1'b0}}};
  localparam logic [REG_W-1:0] HI_RST  = {1'b0, {(REG_W-1){1'b1}}};

  logic [REG_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      lo_q   <= LO_RST;
      hi_q   <= HI_RST;
      conv_q <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          2'd1: cfg_q <= wdata;
          2'd2: lo_q  <= wdata;
          2'd3: hi_q  <= wdata;
          default: ;
        endcase
      end
      if (res_fire) conv_q <= {res_data, {SHIFT{1'b0}}};
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = conv_q;
      2'd1:    rdata = cfg_q;
      2'd2:    rdata = lo_q;
      default: rdata = hi_q;
    endcase
  end

  assign ctl_bits = cfg_q[4:0];

  assert_conv_readonly_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && !res_fire) |=> $stable(conv_q));
endmodule

// File: rtl/adc_alert_fault.sv
module adc_alert_fault
  import adc_alert_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_fire,
  input  logic [REG_W-1:0] sample,
  input  logic [REG_W-1:0] lo,
  input  logic [REG_W-1:0] hi,
  input  ctl_t             ctl,
  input  logic             dis,
  output logic             reach,
  output logic             clear_ok
);
  logic [CNT_W-1:0] cnt_q, cnt_d, need, cnt_plus;
  logic above, below, fault;

  assign above    = $signed(sample) > $signed(hi);
  assign below    = $signed(sample) < $signed(lo);
  assign fault    = ctl.win ? (above || below) : above;
  assign clear_ok = ctl.win ? !fault : below;
  assign need     = need_count(ctl.queue);
  assign cnt_plus = cnt_q + 1'b1;
  assign reach    = res_fire && fault && !dis && (cnt_plus >= need);

  always_comb begin
    cnt_d = cnt_q;
    if (dis)                 cnt_d = '0;
    else if (res_fire) begin
      if (!fault)            cnt_d = '0;
      else if (cnt_plus >= need) cnt_d = need;
      else                   cnt_d = cnt_plus;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_run_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_fire && !fault) |=> cnt_q == '0);
  assert_off_no_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> cnt_q == '0);
endmodule

// File: rtl/adc_alert_out.sv
module adc_alert_out
  import adc_alert_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic res_fire,
  input  logic reach,
  input  logic clear_ok,
  input  ctl_t ctl,
  input  logic dis,
  input  logic conv_rd,
  output logic alert_o
);
  logic active_q, active_d;

  always_comb begin
    active_d = active_q;
    if (dis)                         active_d = 1'b0;
    else if (reach)                  active_d = 1'b1;
    else if (ctl.latch) begin
      if (conv_rd)                   active_d = 1'b0;
    end else if (res_fire && clear_ok) active_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  assign alert_o = ctl.pol_hi ? active_q : !active_q;

  assert_off_inactive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.queue == QUEUE_OFF) |-> !active_q);
  assert_fire_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reach |=> active_q);
  assert_latch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && ctl.latch && !conv_rd && !dis) |=> active_q);
endmodule

// File: rtl/adc_alert_cmp.sv
module adc_alert_cmp
  import adc_alert_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  output logic              alert_o
);
  localparam int SHIFT = REG_W - DATA_W;

  logic [4:0]       ctl_bits;
  logic [REG_W-1:0] lo_q, hi_q, conv_q;
  logic [REG_W-1:0] sample;
  ctl_t             ctl;
  logic             res_fire, dis, conv_rd, reach, clear_ok;

  assign res_ready = 1'b1;
  assign res_fire  = res_valid && res_ready;
  assign ctl       = ctl_t'(ctl_bits);
  assign sample    = {res_data, {SHIFT{1'b0}}};
  assign conv_rd   = reg_rd_en && reg_addr == 2'd0;
  assign dis       = (ctl.queue == QUEUE_OFF) ||
                     (reg_wr_en && reg_addr == 2'd1 && reg_wdata[1:0] == QUEUE_OFF);

  adc_alert_regs #(.REG_W(REG_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .res_fire(res_fire), .res_data(res_data),
    .rdata(reg_rdata), .ctl_bits(ctl_bits), .lo_q(lo_q), .hi_q(hi_q),
    .conv_q(conv_q)
  );

  adc_alert_fault #(.REG_W(REG_W)) u_fault (
    .clk(clk), .rst_n(rst_n), .res_fire(res_fire), .sample(sample),
    .lo(lo_q), .hi(hi_q), .ctl(ctl), .dis(dis), .reach(reach),
    .clear_ok(clear_ok)
  );

  adc_alert_out u_out (
    .clk(clk), .rst_n(rst_n), .res_fire(res_fire), .reach(reach),
    .clear_ok(clear_ok), .ctl(ctl), .dis(dis), .conv_rd(conv_rd),
    .alert_o(alert_o)
  );

  assert_conv_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_fire |=> conv_q == $past(sample));
endmodule

// File: tb/adc_alert_cmp_bench.sv
module adc_alert_cmp_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        reg_wr_en = 0, reg_rd_en = 0, res_valid = 0;
  logic [1:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [11:0] res_data = 0;
  logic        res_ready, alert_o;

  int checks = 0, failures = 0;

  logic [15:0] m_cfg, m_lo, m_hi, m_conv;
  int          m_cnt;
  logic        m_act;

  adc_alert_cmp u_adc_alert_cmp (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .alert_o(alert_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int need_of(input logic [1:0] q);
    return (q == 2'd0) ? 1 : (q == 2'd1) ? 2 : (q == 2'd2) ? 4 : 0;
  endfunction

  function automatic logic exp_pin();
    return m_cfg[3] ? m_act : !m_act;
  endfunction

  function automatic logic [15:0] model_reg(input logic [1:0] a);
    case (a)
      2'd0: return m_conv;
      2'd1: return m_cfg;
      2'd2: return m_lo;
      default: return m_hi;
    endcase
  endfunction

  // One clock cycle: drive at negedge, update model, check pin at next negedge
  task automatic cyc(input string req, input logic wr, input logic rd, input logic [1:0] a,
                     input logic [15:0] wd, input logic v, input logic [11:0] d);
    logic dis, fault, clr, reach;
    logic signed [15:0] s;
    int need;
    reg_wr_en = wr; reg_rd_en = rd; reg_addr = a; reg_wdata = wd;
    res_valid = v; res_data = d;
    #1;
    if (rd) check({req, " rdata"}, reg_rdata, model_reg(a));
    s = {d, 4'b0};
    need = need_of(m_cfg[1:0]);
    dis = (m_cfg[1:0] == 2'd3) || (wr && a == 2'd1 && wd[1:0] == 2'd3);
    if (m_cfg[4]) begin
      fault = (s > $signed(m_hi)) || (s < $signed(m_lo));
      clr = !fault;
    end else begin
      fault = s > $signed(m_hi);
      clr = s < $signed(m_lo);
    end
    reach = v && fault && !dis && (m_cnt + 1 >= need);
    if (dis) m_act = 0;
    else if (reach) m_act = 1;
    else if (m_cfg[2]) begin
      if (rd && a == 2'd0) m_act = 0;
    end else if (v && clr) m_act = 0;
    if (dis) m_cnt = 0;
    else if (v) m_cnt = !fault ? 0 : (m_cnt + 1 >= need) ? need : m_cnt + 1;
    if (wr) case (a)
      2'd1: m_cfg = wd;
      2'd2: m_lo = wd;
      2'd3: m_hi = wd;
      default: ;
    endcase
    if (v) m_conv = s;
    @(negedge clk);
    reg_wr_en = 0; reg_rd_en = 0; res_valid = 0;
    check({req, " alert_o"}, {15'd0, alert_o}, {15'd0, exp_pin()});
  endtask

  task automatic wr_reg(input string req, input logic [1:0] a, input logic [15:0] wd);
    cyc(req, 1, 0, a, wd, 0, 0);
  endtask
  task automatic rd_reg(input string req, input logic [1:0] a);
    cyc(req, 0, 1, a, 0, 0, 0);
  endtask
  task automatic feed(input string req, input logic [11:0] d);
    cyc(req, 0, 0, 0, 0, 1, d);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_cfg = 16'h0003; m_lo = 16'h8000; m_hi = 16'h7FFF; m_conv = 0;
    m_cnt = 0; m_act = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    check("R2 alert", {15'd0, alert_o}, 16'd1);
    check("R11 ready", {15'd0, res_ready}, 16'd1);
    reg_addr = 2'd0; #1 check("R2 conv", reg_rdata, 16'h0000);
    reg_addr = 2'd1; #1 check("R2 cfg", reg_rdata, 16'h0003);
    reg_addr = 2'd2; #1 check("R2 lo", reg_rdata, 16'h8000);
    reg_addr = 2'd3; #1 check("R2 hi", reg_rdata, 16'h7FFF);
    // R1 conversion register read-only
    wr_reg("R1", 2'd0, 16'h1234);
    rd_reg("R1 conv", 2'd0);
    check("R1 conv kept", reg_rdata, 16'h0000);
    // R9 disabled after reset: faults ignored
    wr_reg("R1", 2'd3, 16'h1000);
    wr_reg("R1", 2'd2, 16'hF000);
    rd_reg("R1 hi", 2'd3);
    feed("R9 off", 12'h7F0);
    check("R9 off alert", {15'd0, alert_o}, 16'd1);
    // R3 queue 1, active-high, traditional
    wr_reg("R8", 2'd1, 16'h0009);
    feed("R3 one fault", 12'h200);
    check("R3 not yet", {15'd0, alert_o}, 16'd0);
    feed("R3 second fault", 12'h200);
    check("R3 asserted", {15'd0, alert_o}, 16'd1);
    feed("R5 between", 12'h000);
    check("R5 hysteresis hold", {15'd0, alert_o}, 16'd1);
    feed("R5 equal lo", 12'hF00);
    check("R5 equal lo hold", {15'd0, alert_o}, 16'd1);
    feed("R5 below lo", 12'hEFF);
    check("R5 released", {15'd0, alert_o}, 16'd0);
    // R4 queue 2 needs four in a row
    wr_reg("R4", 2'd1, 16'h000A);
    feed("R4", 12'h200); feed("R4", 12'h200); feed("R4", 12'h200);
    feed("R4 break", 12'h000);
    feed("R4", 12'h200);
    check("R4 run broken", {15'd0, alert_o}, 16'd0);
    feed("R4", 12'h200); feed("R4", 12'h200);
    check("R4 three", {15'd0, alert_o}, 16'd0);
    feed("R4", 12'h200);
    check("R4 fourth", {15'd0, alert_o}, 16'd1);
    // R6 window mode, queue 0
    wr_reg("R6", 2'd1, 16'h0018);
    feed("R6 low fault", 12'hE00);
    check("R6 low asserts", {15'd0, alert_o}, 16'd1);
    feed("R6 in range", 12'h050);
    check("R6 in range clears", {15'd0, alert_o}, 16'd0);
    // R7 latch
    wr_reg("R7", 2'd1, 16'h001C);
    feed("R7 fault", 12'h300);
    feed("R7 in range", 12'h000);
    check("R7 held", {15'd0, alert_o}, 16'd1);
    rd_reg("R7 read conv", 2'd0);
    check("R7 released", {15'd0, alert_o}, 16'd0);
    // R9 write off clears latched alert
    feed("R9 fault", 12'h300);
    check("R9 latched", {15'd0, alert_o}, 16'd1);
    wr_reg("R9 off", 2'd1, 16'h001F);
    check("R9 cleared", {15'd0, alert_o}, 16'd0);
    feed("R9 ignored", 12'h300);
    check("R9 stays off", {15'd0, alert_o}, 16'd0);
    // R8 active-low
    wr_reg("R8", 2'd1, 16'h0000);
    check("R8 low idle", {15'd0, alert_o}, 16'd1);
    feed("R8 fault", 12'h400);
    check("R8 low active", {15'd0, alert_o}, 16'd0);
    // R10 signed compare and alignment
    wr_reg("R10", 2'd1, 16'h0003);
    wr_reg("R10", 2'd3, 16'h0010);
    wr_reg("R10", 2'd1, 16'h0008);
    feed("R10 negative", 12'hF00);
    check("R10 no fault", {15'd0, alert_o}, 16'd0);
    rd_reg("R10 conv", 2'd0);
    check("R10 aligned", reg_rdata, 16'hF000);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 15);
      logic [11:0] d = 12'($urandom_range(0, 4095));
      logic [1:0]  a = 2'($urandom_range(0, 3));
      logic [15:0] w = 16'($urandom);
      if (op == 0) cyc("R1 rand wr", 1, 0, a, (a == 2'd1) ? {11'd0, w[4:0]} : w, 0, 0);
      else if (op == 1) cyc("R7 rand rd", 0, 1, a, 0, 0, 0);
      else if (op == 2) cyc("R3 rand mix", 0, 1, 2'd0, 0, 1, d);
      else cyc("R5 R6 rand feed", 0, 0, 0, 0, 1, d);
      check("R11 ready", {15'd0, res_ready}, 16'd1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule